// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external 256K x 8 asynchronous static RAM that has two chip selects of opposite polarity. The host raises a request strobe with a direction flag, an 18-bit address and, for writes, a byte of data. The sequencer turns that into timed pin activity. It latches the address, asserts both selects, and then either holds output enable low for a counted read window or runs a guarded write. Each wait-state count is the ceiling of a nanosecond timing parameter divided by the clock period, so a new speed grade or clock frequency only needs new parameter values.

The write is built so that the write window opens on the falling edge of write enable. Both selects are already active and output enable is already high at that point. The window closes on the rising edge of write enable, while the selects and data stay in place for one more cycle. The bus is turned around safely. The controller's data driver stays off for a bus-release interval after output enable goes high. It is switched on one cycle before write enable falls.

A park input holds the memory deselected for low-power retention. When park is released, the block waits one full read-cycle time before it accepts any access.

The state machine has eight states:
- IDLE: ready, memory deselected.
- READ: output enable low.
- WTURN: selected, output enable high, driver off.
- WDATA: driver on, write enable high.
- WPULSE: write enable low.
- WHOLD: write enable high, driver still on.
- PARK: deselected, not ready.
- RECOV: deselected, counting the recovery time.

The transitions are:
- IDLE goes to PARK when park is requested. Park wins over a request in the same cycle.
- IDLE goes to READ or WTURN on an accepted request.
- READ goes to IDLE when its count expires.
- WTURN goes to WDATA when its count expires.
- WDATA goes to WPULSE after one cycle.
- WPULSE goes to WHOLD when its count expires.
- WHOLD goes to IDLE after one cycle.
- PARK goes to RECOV when park is released.
- RECOV goes back to PARK if park is raised again.
- RECOV goes to IDLE when its count expires.

Top module: `asram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, host_ready is 1, host_rvalid is 0, mem_sel_n is 1, mem_sel_p is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dq_oe is 0.
- R2: The two selects always change together. The memory is selected (mem_sel_n=0, mem_sel_p=1) in every busy cycle of an access, and never when the block is idle, parked or recovering.
- R3: A read keeps mem_oe_n low for ceil(T_RC_NS/CLK_NS) cycles (11 with the defaults). It samples mem_dq_i at the end of the last of those cycles. The sampled byte appears on host_rdata in the next cycle, which is also the cycle in which host_ready returns.
- R4: A write holds mem_we_n low for N_WP cycles (8 with the defaults). This gives a pulse of at least T_WP_NS, data stable at least T_DW_NS before write enable rises, and an address stable at least T_AW_NS before it rises. The byte is stored at the latched address.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0. Before each write, mem_oe_n is high and the driver is off for ceil(T_BUSREL_NS/CLK_NS) cycles (4 with the defaults). The driver turns on one cycle before write enable falls and stays on for one cycle after it rises.
- R6: host_ready is 0 for 14 cycles during a write and for 11 during a read (defaults). A request made while host_ready is 0 has no effect.
- R7: If park_req is 1 while idle, the next cycle shows host_ready=0 with both selects inactive. This holds even if a request arrives in the same cycle, and any request made while parked has no effect.
- R8: After park_req falls, host_ready stays 0 for ceil(T_RC_NS/CLK_NS) cycles (11 with the defaults) with both selects inactive.
- R9: Address and write data are captured on the cycle a request is accepted. Later changes on the host inputs do not alter the access.
- R10: host_rvalid is a single-cycle pulse, given exactly once for each accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request strobe, taken when host_ready is 1 |
| host_wr | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read-complete pulse |
| host_ready | output | 1 | Idle and able to accept a request |
| park_req | input | 1 | Retention request, level sensitive |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_n | output | 1 | Active-low select |
| mem_sel_p | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data to the memory |
| mem_dq_oe | output | 1 | Enable of the data pad driver |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
The bench builds the block with its default parameters: a 5 ns clock and the 55 ns speed grade. These give an 11-cycle read and recovery window, a 4-cycle bus release and an 8-cycle write pulse, so every wait-state boundary falls on a countable cycle. A behavioural memory model measures the real pulse width, data setup, address setup and output-enable lead of every write in nanoseconds. It returns unknown data for any read sampled before its access time, so a read that is one cycle short shows up as a data mismatch. Back-to-back read/write turnarounds, the highest and lowest addresses, requests made while busy or parked, and a request that collides with park are all driven through the ports.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WTURN,
        ST_WDATA,
        ST_WPULSE,
        ST_WHOLD,
        ST_PARK,
        ST_RECOV
    } asram_state_e;

    // ceiling division for nanosecond-to-cycle conversion
    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wcnt.sv
`timescale 1ns/1ps
module asram_wcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CW     = 4,
    parameter int N_RD   = 11,
    parameter int N_TURN = 4,
    parameter int N_WP   = 8,
    parameter int N_RC   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          park,
    input  logic          cnt_zero,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          ready,
    output logic          accept,
    output logic          capture,
    output logic          sel,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe
);
    asram_state_e st_q, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nx;
    end

    // next state and wait-count loading
    always_comb begin
        st_nx    = st_q;
        load     = 1'b0;
        load_val = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (park) begin
                    st_nx = ST_PARK;
                end else if (req) begin
                    load = 1'b1;
                    if (wr) begin
                        st_nx    = ST_WTURN;
                        load_val = CW'(N_TURN - 1);
                    end else begin
                        st_nx    = ST_READ;
                        load_val = CW'(N_RD - 1);
                    end
                end
            end
            ST_READ:   if (cnt_zero) st_nx = ST_IDLE;
            ST_WTURN:  if (cnt_zero) st_nx = ST_WDATA;
            ST_WDATA: begin
                st_nx    = ST_WPULSE;
                load     = 1'b1;
                load_val = CW'(N_WP - 1);
            end
            ST_WPULSE: if (cnt_zero) st_nx = ST_WHOLD;
            ST_WHOLD:  st_nx = ST_IDLE;
            ST_PARK: begin
                if (!park) begin
                    st_nx    = ST_RECOV;
                    load     = 1'b1;
                    load_val = CW'(N_RC - 1);
                end
            end
            ST_RECOV: begin
                if (park)
                    st_nx = ST_PARK;
                else if (cnt_zero)
                    st_nx = ST_IDLE;
            end
        endcase
    end

    // pin controls, registered from the next state so pins follow the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel   <= 1'b0;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            sel   <= st_nx inside {ST_READ, ST_WTURN, ST_WDATA, ST_WPULSE, ST_WHOLD};
            oe_n  <= (st_nx != ST_READ);
            we_n  <= (st_nx != ST_WPULSE);
            dq_oe <= st_nx inside {ST_WDATA, ST_WPULSE, ST_WHOLD};
        end
    end

    assign ready   = (st_q == ST_IDLE);
    assign accept  = ready && req && !park;
    assign capture = (st_q == ST_READ) && cnt_zero;
endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr    <= '0;
            mem_dq_o    <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= host_addr;
                mem_dq_o <= host_wdata;
            end
            if (capture)
                host_rdata <= mem_dq_i;
            host_rvalid <= capture;
        end
    end
endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 5,
    parameter int T_RC_NS     = 55,
    parameter int T_WC_NS     = 55,
    parameter int T_WP_NS     = 40,
    parameter int T_DW_NS     = 25,
    parameter int T_AW_NS     = 45,
    parameter int T_BUSREL_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              host_ready,
    input  logic              park_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel_p,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int N_RD   = imax(1, cdiv(T_RC_NS, CLK_NS));
    localparam int N_RC   = N_RD;
    localparam int N_TURN = imax(1, cdiv(T_BUSREL_NS, CLK_NS));
    localparam int N_WP   = imax(imax(1, imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS))),
                                 imax(cdiv(T_AW_NS, CLK_NS) - N_TURN - 1,
                                      cdiv(T_WC_NS, CLK_NS) - N_TURN - 2));
    localparam int CW     = $clog2(imax(imax(N_RD, N_TURN), N_WP) + 1);

    logic          load, cnt_zero, accept, capture, sel;
    logic [CW-1:0] load_val;

    asram_fsm #(
        .CW(CW), .N_RD(N_RD), .N_TURN(N_TURN), .N_WP(N_WP), .N_RC(N_RC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr), .park(park_req),
        .cnt_zero(cnt_zero), .load(load), .load_val(load_val), .ready(host_ready),
        .accept(accept), .capture(capture), .sel(sel), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .dq_oe(mem_dq_oe)
    );

    asram_wcnt #(.W(CW)) wcnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(cnt_zero)
    );

    asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) dpath_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .host_addr(host_addr), .host_wdata(host_wdata), .mem_dq_i(mem_dq_i),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid)
    );

    assign mem_sel_n = !sel;
    assign mem_sel_p = sel;
endmodule

// File: rtl/asram_ctl_chk.sv
`timescale 1ns/1ps
module asram_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic host_ready,
    input logic host_rvalid,
    input logic park_req,
    input logic mem_sel_n,
    input logic mem_sel_p,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);
    // R5
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R4
    we_needs_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_sel_n && mem_sel_p));

    // R5
    we_fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(mem_oe_n)));

    // R10
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R6
    ready_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_sel_n && !mem_sel_p && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R7
    park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && park_req) |=> (!host_ready && mem_sel_n && !mem_sel_p));
endmodule

bind asram_ctl asram_ctl_chk chk_i (.*);

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;
    localparam int AW = 18;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, host_wr = 1'b0, park_req = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata, mem_dq_o;
    logic          host_rvalid, host_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_i;

    always #2.5 clk = ~clk;

    asram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .host_ready(host_ready), .park_req(park_req),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int n_cmp = 0, n_bad = 0, n_reads = 0, n_valids = 0;
    bit done = 1'b0;
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] mem [int];
    logic [DW-1:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- behavioural memory model ----------------
    wire m_sel = !mem_sel_n && mem_sel_p;
    wire m_wr  = m_sel && !mem_we_n;
    realtime t_addr = 0, t_sel = 0, t_oe = 0, t_oerise = 0, t_data = 0, t_ws = 0;

    always @(mem_addr)             t_addr   = $realtime;
    always @(m_sel)                t_sel    = $realtime;
    always @(negedge mem_oe_n)     t_oe     = $realtime;
    always @(posedge mem_oe_n)     t_oerise = $realtime;
    always @(mem_dq_o or mem_dq_oe) t_data  = $realtime;

    always @(posedge m_wr) if (rst_n) begin
        t_ws = $realtime;
        chk(mem_dq_oe === 1'b1, "R5 driver on before write opens", 32'(mem_dq_oe), 1);
        chk(($realtime - t_oerise) >= 20.0, "R5 output enable lead before write",
            int'($realtime - t_oerise), 20);
    end

    always @(negedge m_wr) if (rst_n) begin
        chk(($realtime - t_ws) >= 40.0, "R4 write pulse width", int'($realtime - t_ws), 40);
        chk(($realtime - t_data) >= 25.0, "R4 data setup", int'($realtime - t_data), 25);
        chk(($realtime - t_addr) >= 45.0, "R4 address to end of write", int'($realtime - t_addr), 45);
        chk(mem_dq_oe === 1'b1 && !$isunknown(mem_dq_o), "R4 defined write data", 32'(mem_dq_o), 0);
        mem[int'(mem_addr)] = mem_dq_o;
    end

    initial begin
        mem_dq_i = 'z;
        forever begin
            #1;
            if (rst_n && (mem_sel_n == mem_sel_p))
                chk(1'b0, "R2 selects split", {mem_sel_n, mem_sel_p}, 2);
            if (m_sel && !mem_oe_n && mem_we_n) begin
                if (mem_dq_oe)
                    chk(1'b0, "R5 bus contention", 1, 0);
                if (($realtime - t_addr) >= 54.0 && ($realtime - t_sel) >= 54.0 &&
                    ($realtime - t_oe) >= 24.0)
                    mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
                else
                    mem_dq_i = 'x;
            end else begin
                mem_dq_i = 'z;
            end
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic rv_prev = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (host_rvalid) begin
            n_valids++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read pulse", 32'(host_rdata), 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(host_rdata === e, "R3 read data", 32'(host_rdata), 32'(e));
            end
        end
        if (host_rvalid && rv_prev)
            chk(1'b0, "R10 read pulse longer than one cycle", 2, 1);
        rv_prev = host_rvalid;
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit intr);
        int busy = 0, wlow = 0, turn = 0, both = 0;
        issue(1'b1, a, d);
        while (!host_ready) begin
            busy++;
            if (!mem_we_n) wlow++;
            if (m_sel && mem_oe_n && !mem_dq_oe) turn++;
            if (m_sel) both++;
            if (intr && busy == 2) begin
                host_req = 1'b1; host_wr = 1'b1; host_addr = a ^ 18'h1; host_wdata = ~d;
            end
            if (intr && busy == 4) host_req = 1'b0;
            @(negedge clk);
        end
        chk(busy == 14, "R6 write busy cycles", busy, 14);
        chk(wlow == 8, "R4 write enable low cycles", wlow, 8);
        chk(turn == 4, "R5 bus release cycles", turn, 4);
        chk(both == 14, "R2 selected cycles in write", both, 14);
        shadow[int'(a)] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int busy = 0, oelow = 0, both = 0;
        exp_q.push_back(shadow[int'(a)]);
        n_reads++;
        issue(1'b0, a, '0);
        while (!host_ready) begin
            busy++;
            if (!mem_oe_n) oelow++;
            if (m_sel) both++;
            @(negedge clk);
        end
        chk(busy == 11, "R6 read busy cycles", busy, 11);
        chk(oelow == 11, "R3 output enable low cycles", oelow, 11);
        chk(both == 11, "R2 selected cycles in read", both, 11);
        chk(host_rvalid === 1'b1, "R3 data with returning ready", 32'(host_rvalid), 1);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        int rec, bad;
        repeat (2) @(negedge clk);
        // R1 during reset
        chk({host_ready, host_rvalid, mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe} === 7'b1010110,
            "R1 reset outputs", {host_ready, host_rvalid, mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe},
            7'b1010110);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after reset
        chk({host_ready, host_rvalid, mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n, mem_dq_oe} === 7'b1010110,
            "R1 first cycle after reset", {host_ready, host_rvalid, mem_sel_n, mem_sel_p, mem_oe_n,
            mem_we_n, mem_dq_oe}, 7'b1010110);

        do_write(18'h00000, 8'h5A, 1'b0);
        do_write(18'h3FFFF, 8'hA5, 1'b0);
        do_write(18'h00001, 8'h3C, 1'b0);
        do_write(18'h12345, 8'h00, 1'b0);
        do_write(18'h12344, 8'hFF, 1'b0);
        do_read(18'h00000);
        do_read(18'h3FFFF);
        do_write(18'h00000, 8'hC3, 1'b0);   // write straight after read
        do_read(18'h00000);
        do_read(18'h00001);
        do_read(18'h12345);

        // R6 / R9: request while busy is ignored; captured address and data are used
        do_write(18'h12345, 8'h77, 1'b1);
        do_read(18'h12344);
        do_read(18'h12345);

        // R7: park wins over a simultaneous request
        while (!host_ready) @(negedge clk);
        park_req = 1'b1;
        host_req = 1'b1; host_wr = 1'b1; host_addr = 18'h00001; host_wdata = 8'hEE;
        @(negedge clk);
        chk(host_ready === 1'b0, "R7 ready low when parked", 32'(host_ready), 0);
        chk(mem_sel_n === 1'b1 && mem_sel_p === 1'b0, "R7 deselected when parked",
            {mem_sel_n, mem_sel_p}, 2);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!(mem_sel_n === 1'b1 && mem_sel_p === 1'b0 && mem_we_n === 1'b1)) bad++;
        end
        chk(bad == 0, "R7 stays parked with request held", bad, 0);
        host_req = 1'b0;
        park_req = 1'b0;
        @(negedge clk);
        rec = 0; bad = 0;
        while (!host_ready && rec < 100) begin
            rec++;
            if (!(mem_sel_n === 1'b1 && mem_sel_p === 1'b0)) bad++;
            @(negedge clk);
        end
        chk(rec == 11, "R8 recovery cycles", rec, 11);
        chk(bad == 0, "R8 deselected during recovery", bad, 0);
        do_read(18'h00001);   // R7 parked request left this byte untouched

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0 && n_valids == n_reads, "R10 one pulse per read", n_valids, n_reads);
        done = 1'b1;
        report();
    end
endmodule